// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets host software run one single-byte transaction at a time against a serial EEPROM on a four-wire SPI link. Software writes one control word. The word holds a command code, an 8-bit byte address, a write-data byte and a start flag. If the command code is valid, the block lowers chip select and shifts out the instruction byte. It then shifts out the address when the command needs one. Last comes either the write byte or, for reads, eight clocks of zeros on MOSI while the device's reply is clocked in. At the end the block drops start by itself, and software polls that flag to learn that the transaction is over.

The block never checks whether a device is present. Every transaction runs to the end, and a read simply keeps whatever MISO carried. The serial clock runs in mode 0, MSB first. Its half period is a parameter counted in system clocks. Chip select stays high for at least one full serial clock period between transactions.

Top module: `spi_eep_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0.
- R2: The control word has these fields: bit 31 is start, bits 18:16 are the command, bits 15:8 are the address and bits 7:0 are the data. Command codes are 0 read status, 1 write status, 2 read data, 3 write data and 4 write enable. A write while start reads 0 loads all fields. Start becomes 1 only if bit 31 is 1 and the command code is 0 to 4. With codes 5 to 7, start stays 0 and chip select never goes low.
- R3: A write while start reads 1 is ignored. The command, address and data fields keep their values and no second transaction is started.
- R4: Chip select stays low for the whole sequence. The number of SCK pulses is 8 for write enable, 16 for the two status commands and 24 for the two data commands.
- R5: The first byte on MOSI is the opcode, MSB first. The opcodes are 0x06 for write enable, 0x05 for read status, 0x01 for write status, 0x03 for read data and 0x02 for write data.
- R6: The data commands send the address byte right after the opcode. The status commands send no address.
- R7: Write status and write data send the data byte as their last byte. The read commands send 0x00 during the reply byte.
- R8: When a read command finishes, the eight bits sampled from MISO in its last eight clocks, first bit as MSB, are in the data field by the time start reads 0. Other commands leave the data field unchanged.
- R9: Start stays 1 while the transaction runs and is cleared only by the block. From chip select rising to the next chip select falling, at least 2*HALF_DIV system clocks pass.
- R10: The link uses mode 0. SCK is low whenever chip select is high. MOSI changes only while SCK is low, and MISO is sampled on SCK rising.
- R11: With no device fitted (MISO held at 1), a read still completes and its data field becomes 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is a control-word write that lands while a transaction is still shifting. It must change nothing, and the only evidence is what it fails to do. The bench starts a read, waits until start and a low chip select can both be seen, and then writes a word with a different command, a different address and start set. After polling completes, it checks that the fields still hold their old values and that chip select fell exactly once. Reads also need the reply placed on exact bit boundaries. For that the bench models the device itself: it counts received bits, decodes the opcode and drives the reply on falling SCK edges only after the header bits.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam int FRAME_W   = 24;
  localparam int BIT_CNT_W = $clog2(FRAME_W + 1);

  localparam int F_START   = 31;
  localparam int F_CMD_LO  = 16;
  localparam int F_ADDR_LO = 8;

  typedef enum logic [2:0] {
    CMD_RDSR  = 3'd0,
    CMD_WRSR  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_WREN  = 3'd4
  } cmd_e;

  function automatic logic cmd_valid(input logic [2:0] c);
    return c <= 3'd4;
  endfunction

  function automatic logic [7:0] cmd_opcode(input logic [2:0] c);
    case (c)
      CMD_RDSR:  return 8'h05;
      CMD_WRSR:  return 8'h01;
      CMD_READ:  return 8'h03;
      CMD_WRITE: return 8'h02;
      default:   return 8'h06;
    endcase
  endfunction

  function automatic logic [BIT_CNT_W-1:0] cmd_bits(input logic [2:0] c);
    case (c)
      CMD_RDSR, CMD_WRSR:   return BIT_CNT_W'(16);
      CMD_READ, CMD_WRITE:  return BIT_CNT_W'(24);
      default:              return BIT_CNT_W'(8);
    endcase
  endfunction

  function automatic logic cmd_is_read(input logic [2:0] c);
    return (c == CMD_RDSR) || (c == CMD_READ);
  endfunction

  // Left-aligned bit stream: opcode first, then address/data as needed.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [2:0] c,
                                                      input logic [7:0] a,
                                                      input logic [7:0] d);
    case (c)
      CMD_WRSR:  return {cmd_opcode(c), d, 8'h00};
      CMD_READ:  return {cmd_opcode(c), a, 8'h00};
      CMD_WRITE: return {cmd_opcode(c), a, d};
      default:   return {cmd_opcode(c), 16'h0000};
    endcase
  endfunction
endpackage

// File: rtl/spi_eep_regs.sv
module spi_eep_regs
  import spi_eep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        clr_start,
  input  logic        cap_en,
  input  logic [7:0]  cap_data,
  output logic        start_o,
  output logic [2:0]  cmd_o,
  output logic [7:0]  addr_o,
  output logic [7:0]  data_o
);
  logic [2:0] wr_cmd;
  assign wr_cmd = wdata[F_CMD_LO +: 3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      cmd_o   <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      if (wr_en && !start_o) begin
        cmd_o   <= wr_cmd;
        addr_o  <= wdata[F_ADDR_LO +: 8];
        data_o  <= wdata[7:0];
        start_o <= wdata[F_START] && cmd_valid(wr_cmd);
      end
      if (clr_start) start_o <= 1'b0;
      if (cap_en)    data_o  <= cap_data;
    end
  end
endmodule

// File: rtl/spi_eep_clkdiv.sv
module spi_eep_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_full
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_eep_engine.sv
module spi_eep_engine
  import spi_eep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] cmd,
  input  logic [7:0] addr,
  input  logic [7:0] data,
  input  logic       tick,
  input  logic       miso,
  output logic       run,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  output logic       xfer_done,
  output logic       clr_start,
  output logic       cap_en,
  output logic [7:0] cap_data
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_e;

  state_e                state;
  logic [FRAME_W-1:0]    frame;
  logic [FRAME_W-1:0]    next_frame;
  logic [BIT_CNT_W-1:0]  nbits;
  logic [BIT_CNT_W-1:0]  bit_idx;
  logic [7:0]            rx;
  logic                  gap_cnt;
  logic                  is_rd;
  logic                  last_bit;

  assign next_frame = build_frame(cmd, addr, data);
  assign last_bit   = (bit_idx == nbits - 1'b1);
  assign run        = (state != S_IDLE);
  assign xfer_done  = (state == S_SHIFT) && tick && sck && last_bit;
  assign clr_start  = (state == S_GAP) && tick && gap_cnt;
  assign cap_en     = xfer_done && is_rd;
  assign cap_data   = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      frame   <= '0;
      nbits   <= '0;
      bit_idx <= '0;
      rx      <= '0;
      gap_cnt <= 1'b0;
      is_rd   <= 1'b0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            frame   <= next_frame;
            nbits   <= cmd_bits(cmd);
            is_rd   <= cmd_is_read(cmd);
            bit_idx <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b0;
            mosi    <= next_frame[FRAME_W-1];
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
              rx  <= {rx[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (last_bit) begin
                cs_n    <= 1'b1;
                mosi    <= 1'b0;
                gap_cnt <= 1'b0;
                state   <= S_GAP;
              end else begin
                frame   <= frame << 1;
                mosi    <= frame[FRAME_W-2];
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
        end
        S_GAP: begin
          if (tick) begin
            if (gap_cnt) state <= S_IDLE;
            else         gap_cnt <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic       start_q;
  logic [2:0] cmd_q;
  logic [7:0] addr_q;
  logic [7:0] data_q;
  logic       div_tick;
  logic       eng_run;
  logic       xfer_done;
  logic       clr_start;
  logic       cap_en;
  logic [7:0] cap_data;

  spi_eep_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .clr_start(clr_start), .cap_en(cap_en), .cap_data(cap_data),
    .start_o(start_q), .cmd_o(cmd_q), .addr_o(addr_q), .data_o(data_q)
  );

  spi_eep_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .tick(div_tick)
  );

  spi_eep_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_q), .cmd(cmd_q), .addr(addr_q),
    .data(data_q), .tick(div_tick), .miso(spi_miso), .run(eng_run),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .xfer_done(xfer_done),
    .clr_start(clr_start), .cap_en(cap_en), .cap_data(cap_data)
  );

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[F_START]          = start_q;
    reg_rdata[F_CMD_LO +: 3]    = cmd_q;
    reg_rdata[F_ADDR_LO +: 8]   = addr_q;
    reg_rdata[7:0]              = data_q;
  end
endmodule

// File: rtl/spi_eep_ctrl_chk.sv
module spi_eep_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        spi_sck,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        tick,
  input logic        xfer_done
);
  logic       sck_d;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_d <= spi_sck;
      if (spi_cs_n)                rise_cnt <= '0;
      else if (spi_sck && !sck_d)  rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R10
  AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R10
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (rise_cnt == 6'd8 || rise_cnt == 6'd16 || rise_cnt == 6'd24)); // R4
  AST_SELECT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[31]) |=> !spi_cs_n); // R4
  AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> spi_cs_n); // R4
  AST_START_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n || tick) |-> reg_rdata[31]); // R9
  AST_CLEAR_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[31]) |-> spi_cs_n); // R9
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rdata[31]) && reg_rdata[31]) |-> $stable(reg_rdata[18:8])); // R3
endmodule

bind spi_eep_ctrl spi_eep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .tick(div_tick),
  .xfer_done(xfer_done)
);

// File: tb/tb_spi_eep_ctrl.sv
module tb_spi_eep_ctrl;
  localparam int HALF_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  spi_eep_ctrl #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  // ---------------- device model and link monitor ----------------
  int          cyc = 0;
  always @(posedge clk) cyc++;

  logic [31:0] s_bits;
  int          s_cnt;
  logic [7:0]  s_op;
  logic [7:0]  resp;
  bit          no_dev = 1'b0;
  int          cs_falls = 0;
  int          rise_cyc = -1;
  int          min_gap = 1000000;
  int          mode_viol = 0;

  always @(negedge spi_cs_n) begin
    s_cnt = 0; s_bits = '0; s_op = '0;
    cs_falls++;
    if (rise_cyc >= 0 && (cyc - rise_cyc) < min_gap) min_gap = cyc - rise_cyc;
    spi_miso = no_dev;
  end
  always @(posedge spi_cs_n) rise_cyc = cyc;

  always @(posedge spi_sck) if (!spi_cs_n) begin
    s_bits = {s_bits[30:0], spi_mosi};
    s_cnt++;
    if (s_cnt == 8) s_op = s_bits[7:0];
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    int hdr;
    hdr = (s_op == 8'h03) ? 16 : 8;
    if (no_dev) spi_miso = 1'b1;
    else if (s_cnt >= hdr && s_cnt < hdr + 8) spi_miso = resp[7 - (s_cnt - hdr)];
    else spi_miso = 1'b0;
  end

  always @(spi_mosi) if (spi_sck && rst_n) mode_viol++;

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!reg_rdata[31]) return;
    end
  endtask

  function automatic logic [31:0] word(bit st, int c, logic [7:0] a, logic [7:0] d);
    return {st, 12'h000, 3'(c), a, d};
  endfunction

  // Expected MOSI stream and length, built independently from the requirements.
  task automatic exp_stream(int c, logic [7:0] a, logic [7:0] d,
                            output int n, output logic [31:0] bits);
    case (c)
      0: begin n = 16; bits = {16'h0, 8'h05, 8'h00}; end
      1: begin n = 16; bits = {16'h0, 8'h01, d}; end
      2: begin n = 24; bits = {8'h0, 8'h03, a, 8'h00}; end
      3: begin n = 24; bits = {8'h0, 8'h02, a, d}; end
      default: begin n = 8; bits = {24'h0, 8'h06}; end
    endcase
  endtask

  task automatic run_cmd(string tag, int c, logic [7:0] a, logic [7:0] d,
                         logic [7:0] r, logic [7:0] exp_data);
    int n; logic [31:0] bits; int falls0;
    resp = r;
    falls0 = cs_falls;
    exp_stream(c, a, d, n, bits);
    reg_write(word(1'b1, c, a, d));
    wait_idle();
    chk({tag, " R9 start cleared"}, {31'b0, reg_rdata[31]}, 32'd0);
    chk({tag, " R4 one select"}, cs_falls - falls0, 32'd1);
    chk({tag, " R4 pulse count"}, s_cnt, n);
    chk({tag, " R5/R6/R7 mosi stream"}, s_bits, bits);
    chk({tag, " R8 control word"}, reg_rdata, word(1'b0, c, a, exp_data));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 pins", {29'b0, spi_cs_n, spi_sck, spi_mosi}, 32'b100);
  endtask

  task automatic t_field_load();
    reg_write(word(1'b0, 2, 8'h44, 8'h77));
    @(negedge clk);
    chk("R2 fields loaded", reg_rdata, word(1'b0, 2, 8'h44, 8'h77));
  endtask

  task automatic t_bad_cmd();
    int falls0 = cs_falls;
    reg_write(word(1'b1, 7, 8'h12, 8'h34));
    repeat (40) @(negedge clk);
    chk("R2 invalid code no start", reg_rdata, word(1'b0, 7, 8'h12, 8'h34));
    chk("R2 invalid code no select", cs_falls - falls0, 32'd0);
  endtask

  task automatic t_busy_write();
    int falls0 = cs_falls;
    resp = 8'h5E;
    reg_write(word(1'b1, 2, 8'h20, 8'h00));
    repeat (20) @(negedge clk);
    chk("R9 start held while busy", {31'b0, reg_rdata[31]}, 32'd1);
    chk("R4 select low while busy", {31'b0, spi_cs_n}, 32'd0);
    reg_write(word(1'b1, 4, 8'hEE, 8'h11));
    wait_idle();
    repeat (4 * HALF_DIV) @(negedge clk);
    chk("R3 busy write ignored", reg_rdata, word(1'b0, 2, 8'h20, 8'h5E));
    chk("R3 no extra transaction", cs_falls - falls0, 32'd1);
  endtask

  task automatic t_no_device();
    no_dev = 1'b1;
    spi_miso = 1'b1;
    run_cmd("R11 absent device read", 2, 8'h10, 8'h00, 8'h00, 8'hFF);
    no_dev = 1'b0;
    spi_miso = 1'b0;
  endtask

  task automatic t_link_rules();
    chk("R9 minimum deselect gap", {31'b0, min_gap >= 2 * HALF_DIV}, 32'd1);
    chk("R10 mosi moved while sck high", mode_viol, 32'd0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_field_load();
    run_cmd("WREN", 4, 8'h00, 8'h00, 8'h00, 8'h00);
    run_cmd("RDSR", 0, 8'h00, 8'h3C, 8'hA5, 8'hA5);
    run_cmd("WRSR", 1, 8'h00, 8'h3C, 8'hFF, 8'h3C);
    run_cmd("WRITE", 3, 8'h5A, 8'hC3, 8'hFF, 8'hC3);
    run_cmd("READ", 2, 8'h81, 8'h00, 8'h96, 8'h96);
    run_cmd("READ2", 2, 8'hFF, 8'h55, 8'h01, 8'h01);
    t_bad_cmd();
    t_busy_write();
    t_no_device();
    t_link_rules();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9: start never cleared, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule